// File: doc/BRIEF.md
# Vectored Interrupt Controller with Mask

This block gathers up to 32 level-sensitive interrupt request lines and reports them to a processor core. Each cycle it copies the request levels into a raw request register. A software-written mask then gates these bits into a masked-pending value. From that value it encodes a vector code and an interrupt request wire for the core. The two highest request inputs are non-maskable. They are gathered into their own status register, drive a separate non-maskable output, and never reach the mask or the vector logic.

When one maskable source is pending, the vector names it directly. When several are pending, the vector carries one shared code, and software reads the masked-pending register to pick which source to serve first. The registers sit on a 32-bit bus addressed by word index, which is the byte address shifted right by two. Only the mask register can be written. The raw request, masked-pending and non-maskable status registers are read-only.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Request inputs 0 to 29 are level-sensitive. One clock after an input is sampled, its bit in the raw request register (word index 1) equals that input level. Bits 30 and 31 of that register read as 0.
- R2: The mask register at word index 0 stores all 32 bits of a write. It reads back the written value from the clock edge that takes the write.
- R3: A write to any word index other than 0 changes no register. The mask, the raw request register, the masked-pending register and the outputs keep their values.
- R4: The masked-pending register at word index 2 always reads the raw request register bitwise-ANDed with the mask.
- R5: When exactly one masked-pending bit i is set (i from 0 to 29), `vec_o` equals 0x31 + i. This shows two clocks after the input change.
- R6: When two or more masked-pending bits are set, `vec_o` equals 0x30.
- R7: When no masked-pending bit is set, `vec_o` is 0. `irq_o` is high exactly when `vec_o` is nonzero.
- R8: Inputs 30 and 31 set bits 0 and 1 of the non-maskable status register (word index 3) one clock after they are sampled. `nmi_o` is high exactly when that register is nonzero. These inputs never affect the raw request register, the masked-pending register, `vec_o` or `irq_o`.
- R9: While `rst_ni` is low, the mask, raw request and non-maskable registers are 0, and `irq_o`, `vec_o` and `nmi_o` are 0.
- R10: A read of any word index above 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 32 | Level request lines. Bits 30 and 31 are non-maskable |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Word index of the accessed register |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Interrupt request to the core, registered |
| vec_o | output | 8 | Vector code, registered |
| nmi_o | output | 1 | Non-maskable interrupt request |

## Verification
The vector path is driven in turn with every single maskable source, every pair of maskable sources, and a long series of pseudo-random request and mask words. The single sources show whether the encoder maps each position to its own code. The pairs show whether any two sources collapse to the shared code rather than to one of them. The random words, whose expected vector is computed from the population count and the lowest set bit, catch masking errors that the structured patterns miss. Separate sweeps over the four non-maskable combinations, alone and mixed with one maskable source, show that those inputs stay out of the vector. Writes to every read-only index show that the mask and the outputs are left untouched.

// File: rtl/vic_pkg.sv
package vic_pkg;
  // word indices of the register map; the pending word's position is fixed
  localparam int unsigned WORD_MASK = 0;
  localparam int unsigned WORD_RAW  = 1;
  localparam int unsigned WORD_PEND = 2;
  localparam int unsigned WORD_NMI  = 3;
endpackage

// File: rtl/vic_capture.sv
module vic_capture #(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned N_NMI = 2,
  localparam int unsigned N_MSK = N_SRC - N_NMI
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  output logic [N_MSK-1:0] raw_o,
  output logic [N_NMI-1:0] nmi_o
);
  logic [N_MSK-1:0] raw_q;
  logic [N_NMI-1:0] nmi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= '0;
      nmi_q <= '0;
    end else begin
      raw_q <= irq_i[N_MSK-1:0];
      nmi_q <= irq_i[N_SRC-1:N_MSK];
    end
  end

  assign raw_o = raw_q;
  assign nmi_o = nmi_q;

  assert_raw_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> raw_q == $past(irq_i[N_MSK-1:0]));

  assert_nmi_capture_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> nmi_q == $past(irq_i[N_SRC-1:N_MSK]));
endmodule

// File: rtl/vic_regs.sv
module vic_regs #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned N_MSK  = 30,
  parameter int unsigned N_NMI  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [N_MSK-1:0]  raw_i,
  input  logic [N_NMI-1:0]  nmi_i,
  output logic [N_MSK-1:0]  pend_o,
  output logic [DATA_W-1:0] rd_data_o
);
  import vic_pkg::*;

  localparam logic [ADDR_W-1:0] IX_MASK = ADDR_W'(WORD_MASK);
  localparam logic [ADDR_W-1:0] IX_RAW  = ADDR_W'(WORD_RAW);
  localparam logic [ADDR_W-1:0] IX_PEND = ADDR_W'(WORD_PEND);
  localparam logic [ADDR_W-1:0] IX_NMI  = ADDR_W'(WORD_NMI);

  logic [DATA_W-1:0] mask_q;
  logic [N_MSK-1:0]  pend;
  logic              wr_mask;

  assign wr_mask = wr_en_i && (addr_i == IX_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (wr_mask) mask_q <= wr_data_i;
  end

  assign pend   = raw_i & mask_q[N_MSK-1:0];
  assign pend_o = pend;

  always_comb begin
    rd_data_o = '0;
    unique case (addr_i)
      IX_MASK: rd_data_o = mask_q;
      IX_RAW:  rd_data_o = {{(DATA_W-N_MSK){1'b0}}, raw_i};
      IX_PEND: rd_data_o = {{(DATA_W-N_MSK){1'b0}}, pend};
      IX_NMI:  rd_data_o = {{(DATA_W-N_NMI){1'b0}}, nmi_i};
      default: rd_data_o = '0;
    endcase
  end

  assert_mask_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == IX_MASK |=> mask_q == $past(wr_data_i));

  assert_ro_write_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i != IX_MASK |=> $stable(mask_q));
endmodule

// File: rtl/vic_encoder.sv
module vic_encoder #(
  parameter int unsigned N_MSK     = 30,
  parameter int unsigned VEC_W     = 8,
  parameter logic [7:0]  VEC_MULTI = 8'h30,
  parameter logic [7:0]  VEC_BASE  = 8'h31,
  localparam int unsigned IDX_W = $clog2(N_MSK),
  localparam int unsigned CNT_W = $clog2(N_MSK + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_MSK-1:0] pend_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [VEC_W-1:0] vec_d;
  logic             any_d;
  logic [VEC_W-1:0] vec_q;
  logic             irq_q;

  always_comb begin
    cnt = '0;
    idx = '0;
    for (int i = 0; i < N_MSK; i++) begin
      if (pend_i[i]) begin
        cnt = cnt + CNT_W'(1);
        idx = IDX_W'(i);
      end
    end
  end

  // priority among several sources is left to software
  always_comb begin
    if (cnt == '0)                vec_d = '0;
    else if (cnt > CNT_W'(1))     vec_d = VEC_W'(VEC_MULTI);
    else                          vec_d = VEC_W'(VEC_BASE) + VEC_W'(idx);
  end

  assign any_d = |pend_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q <= '0;
      irq_q <= 1'b0;
    end else begin
      vec_q <= vec_d;
      irq_q <= any_d;
    end
  end

  assign vec_o = vec_q;
  assign irq_o = irq_q;

  assert_single_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(pend_i) |=> vec_o != VEC_W'(VEC_MULTI) && vec_o != '0);

  assert_multi_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pend_i) > 1 |=> vec_o == VEC_W'(VEC_MULTI));

  assert_idle_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i == '0 |=> vec_o == '0 && !irq_o);

  assert_irq_matches_vec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (vec_o != '0));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int unsigned N_SRC     = 32,
  parameter int unsigned N_NMI     = 2,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned VEC_W     = 8,
  parameter logic [7:0]  VEC_MULTI = 8'h30,
  parameter logic [7:0]  VEC_BASE  = 8'h31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              nmi_o
);
  localparam int unsigned N_MSK = N_SRC - N_NMI;

  logic [N_MSK-1:0] raw;
  logic [N_NMI-1:0] nmi;
  logic [N_MSK-1:0] pend;

  vic_capture #(.N_SRC(N_SRC), .N_NMI(N_NMI)) u_capture (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .raw_o  (raw),
    .nmi_o  (nmi)
  );

  vic_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_MSK(N_MSK), .N_NMI(N_NMI)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .raw_i     (raw),
    .nmi_i     (nmi),
    .pend_o    (pend),
    .rd_data_o (rd_data_o)
  );

  vic_encoder #(.N_MSK(N_MSK), .VEC_W(VEC_W), .VEC_MULTI(VEC_MULTI), .VEC_BASE(VEC_BASE)) u_enc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend),
    .irq_o  (irq_o),
    .vec_o  (vec_o)
  );

  assign nmi_o = |nmi;

  assert_nmi_out_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> nmi_o == ($past(irq_i[N_SRC-1:N_MSK]) != '0));

  assert_reset_quiet_R9: assert property (@(posedge clk_i)
    !rst_ni |-> !irq_o && vec_o == '0 && !nmi_o);
endmodule

// File: tb/vec_irq_ctrl_bench.sv
module vec_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] irq_i = '0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o;
  logic [7:0]  vec_o;
  logic        nmi_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  vec_irq_ctrl u_vec_irq_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .irq_o(irq_o), .vec_o(vec_o), .nmi_o(nmi_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rd_data_o;
  endtask

  // drive at a falling edge, then let capture and output registers settle
  task automatic apply(input logic [31:0] p);
    @(negedge clk_i);
    irq_i = p;
    repeat (2) @(negedge clk_i);
  endtask

  function automatic logic [7:0] exp_vec(input logic [31:0] p, input logic [31:0] m);
    logic [29:0] pd;
    int c;
    int ix;
    pd = p[29:0] & m[29:0];
    c = 0; ix = 0;
    for (int k = 0; k < 30; k++) if (pd[k]) begin c++; ix = k; end
    if (c == 0) return 8'h00;
    if (c > 1)  return 8'h30;
    return 8'(8'h31 + ix);
  endfunction

  task automatic check_all(input string tag, input logic [31:0] p, input logic [31:0] m);
    logic [31:0] d;
    logic [7:0]  ev;
    ev = exp_vec(p, m);
    chk({tag, " R5/R6 vec"}, {24'h0, vec_o}, {24'h0, ev});
    chk({tag, " R7 irq"}, {31'h0, irq_o}, {31'h0, ev != 8'h00});
    rd_reg(8'd1, d); chk({tag, " R1 raw"}, d, {2'b00, p[29:0]});
    rd_reg(8'd2, d); chk({tag, " R4 pend"}, d, {2'b00, p[29:0] & m[29:0]});
    rd_reg(8'd3, d); chk({tag, " R8 nmi reg"}, d, {30'h0, p[31:30]});
    chk({tag, " R8 nmi out"}, {31'h0, nmi_o}, {31'h0, p[31:30] != 2'b00});
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] lfsr;
    logic [31:0] m;

    // R9 reset state, with requests active during reset
    irq_i = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk_i);
    chk("R9 vec", {24'h0, vec_o}, 32'h0);
    chk("R9 irq", {31'h0, irq_o}, 32'h0);
    chk("R9 nmi", {31'h0, nmi_o}, 32'h0);
    for (int a = 0; a < 4; a++) begin
      rd_reg(8'(a), d); chk("R9 reg", d, 32'h0);
    end
    irq_i = '0;
    rst_ni = 1'b1;

    // R2 mask read-back
    wr_reg(8'd0, 32'hA5A5_5A5A);
    rd_reg(8'd0, d); chk("R2 mask", d, 32'hA5A5_5A5A);
    wr_reg(8'd0, 32'hFFFF_FFFF);
    rd_reg(8'd0, d); chk("R2 mask", d, 32'hFFFF_FFFF);

    // R5 every single source
    for (int i = 0; i < 30; i++) begin
      apply(32'h1 << i);
      check_all("single", 32'h1 << i, 32'hFFFF_FFFF);
    end

    // R6 every pair
    for (int i = 0; i < 30; i++)
      for (int j = i + 1; j < 30; j++) begin
        apply((32'h1 << i) | (32'h1 << j));
        chk("R6 pair vec", {24'h0, vec_o}, 32'h30);
        chk("R7 pair irq", {31'h0, irq_o}, 32'h1);
      end

    // R7 idle
    apply(32'h0);
    check_all("idle", 32'h0, 32'hFFFF_FFFF);

    // R4/R5 masking reduces a pair to one source
    wr_reg(8'd0, ~(32'h1 << 5));
    apply(32'h1 << 5);
    check_all("masked out", 32'h1 << 5, ~(32'h1 << 5));
    apply((32'h1 << 5) | (32'h1 << 7));
    check_all("masked pair", (32'h1 << 5) | (32'h1 << 7), ~(32'h1 << 5));
    chk("R5 masked pair", {24'h0, vec_o}, 32'h38);

    // R8 non-maskable inputs alone and mixed
    wr_reg(8'd0, 32'hFFFF_FFFF);
    for (int k = 0; k < 4; k++) begin
      apply(32'(k) << 30);
      check_all("nmi only", 32'(k) << 30, 32'hFFFF_FFFF);
      apply((32'(k) << 30) | 32'h8);
      check_all("nmi mix", (32'(k) << 30) | 32'h8, 32'hFFFF_FFFF);
      chk("R8 mix vec", {24'h0, vec_o}, 32'h34);
    end

    // R3 writes to read-only indices
    wr_reg(8'd0, 32'h1234_5678);
    apply(32'hC000_0010);
    for (int a = 1; a < 6; a++) begin
      wr_reg(8'(a), 32'hFFFF_FFFF);
      @(negedge clk_i);
      rd_reg(8'd0, d); chk("R3 mask kept", d, 32'h1234_5678);
      check_all("R3 ro write", 32'hC000_0010, 32'h1234_5678);
    end

    // R10 unmapped indices
    rd_reg(8'd4, d);   chk("R10 idx4", d, 32'h0);
    rd_reg(8'd255, d); chk("R10 idx255", d, 32'h0);

    // pseudo-random requests and masks
    lfsr = 32'hACE1_2468;
    for (int t = 0; t < 300; t++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      m = lfsr ^ 32'h5A5A_F00F;
      if (t % 4 == 0) wr_reg(8'd0, m);
      else            rd_reg(8'd0, m);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      d = (t % 3 == 0) ? (lfsr & (lfsr >> 7)) : lfsr;
      apply(d);
      check_all("random", d, m);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule